// File: doc/BRIEF.md
# Buffer Descriptor Sequencer

This block keeps the buffer descriptors of a MAC in a register-mapped table and steps through them for the frame datapath. Every table entry holds two 32-bit words. The first word carries ownership, control flags, completion flags and a length. The second word carries a buffer address. One table holds both rings. The first entries, up to a programmable count, form the transmit ring. The entries after them form the receive ring.

Software fills a transmit entry and sets its ownership bit. The sequencer then passes the buffer address, the length and the per-frame options to a transmit stub. When the stub reports completion, the sequencer writes the outcome flags back into the entry and returns ownership to software in the same cycle. On the receive side, the sequencer offers the address of the current empty entry to a receive stub. When a frame ends, it stores the length and flags in that entry and clears the empty bit. Each ring steps forward one entry at a time. It goes back to its own first entry when an entry carries the wrap flag, or after the last entry available to that ring. Interrupt sources are set from these events and cleared by writing ones.

Top module: `bd_sequencer`

## Requirements
- R1: Entry i of the table has its status word at byte offset 0x400 + 8*i and its address word at 0x400 + 8*i + 4. Both words can be written and read back. After reset every word of the table reads zero, every register reads zero, tx_req and rx_ready are low and irq is low.
- R2: A write to the transmit-count register (offset 0x08) stores the written value, clamped to the table size (128). Entries at or above the count belong to the receive ring.
- R3: When transmit is enabled (control register at 0x00, bit 1) and the entry at the transmit pointer has bit 15 (ready) set, tx_req rises. While tx_req is high, the address word appears on tx_buf_addr, bits 31:16 on tx_len, bit 12 on tx_pad and bit 11 on tx_crc. No request is made while bit 15 is clear.
- R4: On tx_done the entry's bits 8:0 take tx_flags (bit 0 carrier lost, 1 deferred, 2 late collision, 3 retry limit, 7:4 retry count, 8 underrun), bit 15 is cleared in that same cycle, and bits 31:16 and 14:9 are kept.
- R5: After a transmit completion the pointer goes to entry 0 if the entry had bit 13 (wrap) set or was the last transmit entry. Otherwise it moves to the next entry.
- R6: A transmit completion with any of flag bits 0, 2, 3 or 8 set raises interrupt bit 1 (transmit error). A completion with none of them set raises interrupt bit 0 (transmit done), and only if the entry had bit 14 set. Deferral and retry count alone are not errors.
- R7: When receive is enabled (control bit 0) and the entry at the receive pointer has bit 15 (empty) set, rx_ready is high and rx_buf_addr shows its address word. On rx_done the entry takes rx_len unchanged (the CRC bytes stay counted) in bits 31:16 and rx_flags in bits 8:0. Bit 15 is cleared, and bits 14:9 are kept.
- R8: The receive pointer starts at the entry whose index equals the transmit count. After a filled entry with bit 13 set, or after entry 127, it goes back to that first receive entry. Otherwise it moves to the next entry.
- R9: An rx_done while receive is enabled and the current entry is not empty changes no entry, leaves the pointer where it is and raises interrupt bit 4 (busy).
- R10: A filled receive entry raises interrupt bit 3 (receive error) if any of rx_flags bits 7:0 is set. If none is set, it raises interrupt bit 2 (receive done), and only if the entry had bit 14 set. Flag bit 8 (control frame) alone is not an error.
- R11: A 0-to-1 change of the transmit enable returns the transmit pointer to entry 0. A 0-to-1 change of the receive enable returns the receive pointer to the first receive entry.
- R12: The interrupt register (offset 0x04) clears the bits written as one. A new event in the same cycle wins over the clear. The irq output is high exactly while any interrupt bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 11 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| tx_req | output | 1 | A transmit buffer is handed to the stub |
| tx_buf_addr | output | 32 | Transmit buffer address |
| tx_len | output | 16 | Transmit frame length |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append CRC |
| tx_done | input | 1 | Transmit stub finished the current frame |
| tx_flags | input | 9 | Transmit outcome flags |
| rx_ready | output | 1 | An empty receive buffer is available |
| rx_buf_addr | output | 32 | Receive buffer address |
| rx_done | input | 1 | Receive stub finished a frame |
| rx_len | input | 16 | Received length including CRC |
| rx_flags | input | 9 | Receive outcome flags |
| irq | output | 1 | Any interrupt source pending |

## Verification
A table of transmit entries drives the main path. The entries differ in the interrupt-request bit, the pad and CRC bits and the wrap bit, and they are paired with flag patterns that are clean, informational only (deferral, retry count) or errors. This separates the write-back merge, the done-versus-error choice, and wrapping on the flag from wrapping at the ring boundary. Directed receive steps then fill entries with clean flags, error flags and the control-frame flag alone. They also deliver a frame into an entry still owned by software. This tells the busy drop apart from a normal fill and shows where the receive pointer goes after a wrap. Enable toggling with two ready entries shows whether the transmit pointer restarts.

// File: rtl/bdseq_pkg.sv
package bdseq_pkg;
  localparam int unsigned OWN_BIT  = 15;
  localparam int unsigned IRQ_BIT  = 14;
  localparam int unsigned WRAP_BIT = 13;
  localparam int unsigned PAD_BIT  = 12;
  localparam int unsigned CRC_BIT  = 11;

  // flag bits that count as a failed transmission / reception
  localparam logic [8:0] TX_ERR_MASK = 9'h10D;
  localparam logic [8:0] RX_ERR_MASK = 9'h0FF;

  // interrupt register layout
  localparam int unsigned EV_TX_OK  = 0;
  localparam int unsigned EV_TX_ERR = 1;
  localparam int unsigned EV_RX_OK  = 2;
  localparam int unsigned EV_RX_ERR = 3;
  localparam int unsigned EV_BUSY   = 4;
  localparam int unsigned EV_W      = 5;

  // status word after completion: new length, ownership dropped,
  // control bits kept, outcome flags replaced
  function automatic logic [31:0] close_status(input logic [31:0] stat,
                                               input logic [15:0] len,
                                               input logic [8:0]  flags);
    return {len, 1'b0, stat[14:9], flags};
  endfunction

  // index following cur inside a ring [first..last]
  function automatic logic [31:0] ring_next(input logic [31:0] cur,
                                            input logic [31:0] first,
                                            input logic [31:0] last,
                                            input logic        wrap);
    return (wrap || cur >= last) ? first : cur + 32'd1;
  endfunction

  function automatic logic [31:0] clamp_count(input logic [31:0] v,
                                              input logic [31:0] lim);
    return (v > lim) ? lim : v;
  endfunction
endpackage

// File: rtl/bdseq_table.sv
module bdseq_table import bdseq_pkg::*; #(
  parameter int N  = 128,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [IW-1:0] sw_idx,
  input  logic          sw_word,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic          tx_wb_en,
  input  logic [IW-1:0] tx_wb_idx,
  input  logic [31:0]   tx_wb_data,
  input  logic          rx_wb_en,
  input  logic [IW-1:0] rx_wb_idx,
  input  logic [31:0]   rx_wb_data,
  input  logic [IW-1:0] tx_rd_idx,
  output logic [31:0]   tx_stat,
  output logic [31:0]   tx_addr,
  input  logic [IW-1:0] rx_rd_idx,
  output logic [31:0]   rx_stat,
  output logic [31:0]   rx_addr
);
  logic [31:0] stat_arr [N];
  logic [31:0] addr_arr [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [31:0] st_q, ad_q;
    // hardware write-back takes precedence over a software write
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= '0;
        ad_q <= '0;
      end else begin
        if (tx_wb_en && tx_wb_idx == IW'(i))           st_q <= tx_wb_data;
        else if (rx_wb_en && rx_wb_idx == IW'(i))      st_q <= rx_wb_data;
        else if (sw_we && !sw_word && sw_idx == IW'(i)) st_q <= sw_wdata;
        if (sw_we && sw_word && sw_idx == IW'(i))       ad_q <= sw_wdata;
      end
    end
    assign stat_arr[i] = st_q;
    assign addr_arr[i] = ad_q;
  end

  assign sw_rdata = sw_word ? addr_arr[sw_idx] : stat_arr[sw_idx];
  assign tx_stat  = stat_arr[tx_rd_idx];
  assign tx_addr  = addr_arr[tx_rd_idx];
  assign rx_stat  = stat_arr[rx_rd_idx];
  assign rx_addr  = addr_arr[rx_rd_idx];

  // R4: a completed transmit entry is back with software next cycle
  a_r4_tx_own_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wb_en |=> !stat_arr[$past(tx_wb_idx)][OWN_BIT]);
  // R7: a filled receive entry is no longer empty next cycle
  a_r7_rx_own_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wb_en |=> !stat_arr[$past(rx_wb_idx)][OWN_BIT]);
endmodule

// File: rtl/bdseq_tx_walker.sv
module bdseq_tx_walker import bdseq_pkg::*; #(
  parameter int N  = 128,
  parameter int IW = $clog2(N),
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  output logic [IW-1:0] rd_idx,
  input  logic [31:0]   stat,
  input  logic [31:0]   addr,
  output logic          req,
  output logic [31:0]   buf_addr,
  output logic [15:0]   len,
  output logic          pad,
  output logic          crc,
  input  logic          done,
  input  logic [8:0]    flags,
  output logic          wb_en,
  output logic [IW-1:0] wb_idx,
  output logic [31:0]   wb_data,
  output logic          ev_ok,
  output logic          ev_err
);
  logic          en_q, busy_q, pad_q, crc_q;
  logic [IW-1:0] ptr_q, bidx_q;
  logic [31:0]   addr_q;
  logic [15:0]   len_q;
  logic          en_rise, launch, done_ev, err;
  logic [IW-1:0] ptr_next;

  assign en_rise  = en & ~en_q;
  assign rd_idx   = busy_q ? bidx_q : ptr_q;
  assign launch   = !busy_q && en && !en_rise && stat[OWN_BIT]
                    && (32'(ptr_q) < 32'(cnt));
  assign done_ev  = busy_q && done;
  assign err      = |(flags & TX_ERR_MASK);
  assign ptr_next = IW'(ring_next(32'(bidx_q), 32'd0, 32'(cnt) - 32'd1,
                                  stat[WRAP_BIT]));

  assign wb_en   = done_ev;
  assign wb_idx  = bidx_q;
  assign wb_data = close_status(stat, stat[31:16], flags);
  assign ev_err  = done_ev & err;
  assign ev_ok   = done_ev & ~err & stat[IRQ_BIT];

  assign req      = busy_q;
  assign buf_addr = addr_q;
  assign len      = len_q;
  assign pad      = pad_q;
  assign crc      = crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      ptr_q  <= '0;
      bidx_q <= '0;
      addr_q <= '0;
      len_q  <= '0;
      pad_q  <= 1'b0;
      crc_q  <= 1'b0;
    end else begin
      en_q <= en;
      if (launch) begin
        busy_q <= 1'b1;
        bidx_q <= ptr_q;
        addr_q <= addr;
        len_q  <= stat[31:16];
        pad_q  <= stat[PAD_BIT];
        crc_q  <= stat[CRC_BIT];
      end else if (done_ev) begin
        busy_q <= 1'b0;
      end
      if (en_rise)      ptr_q <= '0;
      else if (done_ev) ptr_q <= ptr_next;
    end
  end

  // R3: a request only starts from an entry owned by hardware
  a_r3_launch_owned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(stat[OWN_BIT]));
  // R5: wrap flag sends the pointer back to entry 0
  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && stat[WRAP_BIT]) |=> (ptr_q == '0));
  // R6: done and error never reported together
  a_r6_tx_ev_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ok, ev_err}));
  // R11: enable edge restarts the ring
  a_r11_tx_restart: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (ptr_q == '0));
endmodule

// File: rtl/bdseq_rx_walker.sv
module bdseq_rx_walker import bdseq_pkg::*; #(
  parameter int N  = 128,
  parameter int IW = $clog2(N),
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  output logic [IW-1:0] rd_idx,
  input  logic [31:0]   stat,
  input  logic [31:0]   addr,
  output logic          ready,
  output logic [31:0]   buf_addr,
  input  logic          done,
  input  logic [15:0]   len,
  input  logic [8:0]    flags,
  output logic          wb_en,
  output logic [IW-1:0] wb_idx,
  output logic [31:0]   wb_data,
  output logic          ev_ok,
  output logic          ev_err,
  output logic          ev_busy
);
  logic          en_q, en_rise, in_ring, accept, err;
  logic [IW-1:0] ptr_q, first_idx, ptr_next;

  assign en_rise   = en & ~en_q;
  assign first_idx = IW'(32'(cnt));
  assign in_ring   = 32'(ptr_q) >= 32'(cnt);
  assign rd_idx    = ptr_q;
  assign ready     = en && !en_rise && in_ring && stat[OWN_BIT];
  assign buf_addr  = addr;
  assign accept    = done && ready;
  assign err       = |(flags & RX_ERR_MASK);
  assign ptr_next  = IW'(ring_next(32'(ptr_q), 32'(cnt), 32'(N - 1),
                                   stat[WRAP_BIT]));

  assign wb_en   = accept;
  assign wb_idx  = ptr_q;
  assign wb_data = close_status(stat, len, flags);
  assign ev_ok   = accept & ~err & stat[IRQ_BIT];
  assign ev_err  = accept & err;
  assign ev_busy = done & en & ~ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ptr_q <= '0;
    end else begin
      en_q <= en;
      if (en_rise)     ptr_q <= first_idx;
      else if (accept) ptr_q <= ptr_next;
    end
  end

  // R8: after a wrap entry the pointer is the first receive entry
  a_r8_rx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && stat[WRAP_BIT]) |=> (ptr_q == $past(first_idx)));
  // R9: a dropped frame leaves the pointer in place
  a_r9_drop_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_busy && !en_rise) |=> $stable(ptr_q));
  // R11: receive enable edge restarts the ring
  a_r11_rx_restart: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (ptr_q == $past(first_idx)));
endmodule

// File: rtl/bd_sequencer.sv
module bd_sequencer import bdseq_pkg::*; #(
  parameter int               N          = 128,
  parameter int               ADDR_W     = 11,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 11'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_req,
  output logic [31:0]       tx_buf_addr,
  output logic [15:0]       tx_len,
  output logic              tx_pad,
  output logic              tx_crc,
  input  logic              tx_done,
  input  logic [8:0]        tx_flags,
  output logic              rx_ready,
  output logic [31:0]       rx_buf_addr,
  input  logic              rx_done,
  input  logic [15:0]       rx_len,
  input  logic [8:0]        rx_flags,
  output logic              irq
);
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N + 1);
  localparam logic [ADDR_W-1:0] CTRL_OFF  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IRQ_OFF   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] TXCNT_OFF = ADDR_W'(8);
  localparam logic [31:0]       TABLE_END = 32'(TABLE_BASE) + 32'(8 * N);

  logic [1:0]      ctrl_q;
  logic [EV_W-1:0] irq_q, ev, clr;
  logic [CW-1:0]   txcnt_q;

  // table window decode
  logic [ADDR_W-1:0] tbl_off;
  logic              tbl_hit, sw_word;
  logic [IW-1:0]     sw_idx;
  logic [31:0]       sw_rdata;
  logic              unused_off;

  assign tbl_off    = reg_addr - TABLE_BASE;
  assign tbl_hit    = (32'(reg_addr) >= 32'(TABLE_BASE)) && (32'(reg_addr) < TABLE_END);
  assign sw_idx     = tbl_off[IW+2:3];
  assign sw_word    = tbl_off[2];
  assign unused_off = ^{tbl_off[1:0], tbl_off[ADDR_W-1:IW+3]};

  // walker <-> table wiring
  logic [IW-1:0] tx_rd_idx, rx_rd_idx, tx_wb_idx, rx_wb_idx;
  logic [31:0]   tx_stat, tx_addr, rx_stat, rx_addr, tx_wb_data, rx_wb_data;
  logic          tx_wb_en, rx_wb_en;
  logic          tx_ok_ev, tx_err_ev, rx_ok_ev, rx_err_ev, rx_busy_ev;

  bdseq_table #(.N(N), .IW(IW)) table_i (
    .clk, .rst_n,
    .sw_we(reg_wr && tbl_hit), .sw_idx, .sw_word, .sw_wdata(reg_wdata), .sw_rdata,
    .tx_wb_en, .tx_wb_idx, .tx_wb_data,
    .rx_wb_en, .rx_wb_idx, .rx_wb_data,
    .tx_rd_idx, .tx_stat, .tx_addr,
    .rx_rd_idx, .rx_stat, .rx_addr
  );

  bdseq_tx_walker #(.N(N), .IW(IW), .CW(CW)) tx_i (
    .clk, .rst_n, .en(ctrl_q[1]), .cnt(txcnt_q),
    .rd_idx(tx_rd_idx), .stat(tx_stat), .addr(tx_addr),
    .req(tx_req), .buf_addr(tx_buf_addr), .len(tx_len), .pad(tx_pad), .crc(tx_crc),
    .done(tx_done), .flags(tx_flags),
    .wb_en(tx_wb_en), .wb_idx(tx_wb_idx), .wb_data(tx_wb_data),
    .ev_ok(tx_ok_ev), .ev_err(tx_err_ev)
  );

  bdseq_rx_walker #(.N(N), .IW(IW), .CW(CW)) rx_i (
    .clk, .rst_n, .en(ctrl_q[0]), .cnt(txcnt_q),
    .rd_idx(rx_rd_idx), .stat(rx_stat), .addr(rx_addr),
    .ready(rx_ready), .buf_addr(rx_buf_addr),
    .done(rx_done), .len(rx_len), .flags(rx_flags),
    .wb_en(rx_wb_en), .wb_idx(rx_wb_idx), .wb_data(rx_wb_data),
    .ev_ok(rx_ok_ev), .ev_err(rx_err_ev), .ev_busy(rx_busy_ev)
  );

  always_comb begin
    ev = '0;
    ev[EV_TX_OK]  = tx_ok_ev;
    ev[EV_TX_ERR] = tx_err_ev;
    ev[EV_RX_OK]  = rx_ok_ev;
    ev[EV_RX_ERR] = rx_err_ev;
    ev[EV_BUSY]   = rx_busy_ev;
  end

  assign clr = (reg_wr && reg_addr == IRQ_OFF) ? reg_wdata[EV_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      irq_q   <= '0;
      txcnt_q <= '0;
    end else begin
      if (reg_wr && reg_addr == CTRL_OFF)  ctrl_q  <= reg_wdata[1:0];
      if (reg_wr && reg_addr == TXCNT_OFF) txcnt_q <= CW'(clamp_count(reg_wdata, 32'(N)));
      irq_q <= (irq_q & ~clr) | ev;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (tbl_hit)                     reg_rdata = sw_rdata;
    else if (reg_addr == CTRL_OFF)   reg_rdata = 32'(ctrl_q);
    else if (reg_addr == IRQ_OFF)    reg_rdata = 32'(irq_q);
    else if (reg_addr == TXCNT_OFF)  reg_rdata = 32'(txcnt_q);
  end

  assign irq = |irq_q;

  // R2: the stored count never exceeds the table size
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == TXCNT_OFF) |=> (32'(txcnt_q) <= 32'(N)));
  // R9: a dropped frame sets the busy source
  a_r9_busy_raised: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy_ev |=> irq_q[EV_BUSY]);
  // R12: the line only rises after an event
  a_r12_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|ev));
endmodule

// File: tb/bd_sequencer_tb.sv
module bd_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [10:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_req, tx_pad, tx_crc, rx_ready, irq;
  logic [31:0] tx_buf_addr, rx_buf_addr;
  logic [15:0] tx_len;
  logic        tx_done = 1'b0, rx_done = 1'b0;
  logic [8:0]  tx_flags = '0, rx_flags = '0;
  logic [15:0] rx_len = '0;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bd_sequencer dut_i (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .tx_req, .tx_buf_addr, .tx_len, .tx_pad, .tx_crc, .tx_done, .tx_flags,
    .rx_ready, .rx_buf_addr, .rx_done, .rx_len, .rx_flags, .irq
  );

  // {status, address, flags, entry, expected irq bits [1:0]}
  localparam logic [95:0] TX_VEC [8] = '{
    {32'h0040_4800, 32'h0000_1000, 16'h0000, 8'd0, 8'h01},
    {32'h0028_1000, 32'h0000_1600, 16'h0002, 8'd1, 8'h00},
    {32'h0064_6000, 32'h0000_1C00, 16'h0008, 8'd2, 8'h02},
    {32'h05DC_4000, 32'h0000_3000, 16'h0030, 8'd0, 8'h01},
    {32'h0200_0800, 32'h0000_3600, 16'h0100, 8'd1, 8'h02},
    {32'h0010_0000, 32'h0000_3C00, 16'h0004, 8'd2, 8'h02},
    {32'h0020_4000, 32'h0000_4200, 16'h0000, 8'd3, 8'h01},
    {32'h0030_4000, 32'h0000_4800, 16'h0001, 8'd0, 8'h02}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [10:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [10:0] ent(input int idx, input int word);
    return 11'(32'h400 + 8 * idx + 4 * word);
  endfunction

  task automatic wait_tx(input string tag);
    int n = 0;
    while (!tx_req && n < 20) begin
      @(negedge clk);
      n++;
    end
    if (!tx_req) check({tag, " tx_req timeout"}, 64'(tx_req), 64'd1);
  endtask

  task automatic pulse_tx(input logic [8:0] f);
    @(negedge clk);
    tx_done = 1'b1; tx_flags = f;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic pulse_rx(input logic [15:0] l, input logic [8:0] f);
    @(negedge clk);
    rx_done = 1'b1; rx_len = l; rx_flags = f;
    @(negedge clk);
    rx_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R12 reset state
    check("R1 reset outputs", {60'd0, tx_req, rx_ready, irq, 1'b0}, 64'd0);
    reg_read(11'h000, rd); check("R1 reset ctrl", 64'(rd), 64'd0);
    reg_read(11'h004, rd); check("R12 reset irq reg", 64'(rd), 64'd0);
    reg_read(11'h008, rd); check("R1 reset count", 64'(rd), 64'd0);
    reg_read(ent(9, 0), rd); check("R1 reset table", 64'(rd), 64'd0);

    // R2 clamp
    reg_write(11'h008, 32'd200);
    reg_read(11'h008, rd); check("R2 clamp", 64'(rd), 64'd128);
    reg_write(11'h008, 32'd4);
    reg_read(11'h008, rd); check("R2 plain count", 64'(rd), 64'd4);

    // R1 table access
    reg_write(ent(5, 1), 32'h1234_5678);
    reg_read(ent(5, 1), rd); check("R1 address word", 64'(rd), 64'h1234_5678);
    reg_write(ent(127, 0), 32'h0000_0055);
    reg_read(ent(127, 0), rd); check("R1 last entry", 64'(rd), 64'h55);
    reg_write(ent(127, 0), 32'h0);

    // R3 no launch while the entry is not ready
    reg_write(11'h000, 32'h2);
    repeat (6) @(negedge clk);
    check("R3 idle without ready", 64'(tx_req), 64'd0);

    // transmit vector walk (R3..R6)
    for (int k = 0; k < 8; k++) begin
      logic [31:0] st, ad, expst;
      logic [8:0]  fl;
      int          idx;
      logic [1:0]  expirq;
      st = TX_VEC[k][95:64]; ad = TX_VEC[k][63:32];
      fl = TX_VEC[k][24:16]; idx = int'(TX_VEC[k][15:8]); expirq = TX_VEC[k][1:0];
      reg_write(ent(idx, 1), ad);
      reg_write(ent(idx, 0), st | 32'h8000);
      wait_tx($sformatf("R5 vec%0d", k));
      check($sformatf("R3 vec%0d handoff", k), {tx_buf_addr, tx_len, 14'd0, tx_pad, tx_crc},
            {ad, st[31:16], 14'd0, st[12], st[11]});
      pulse_tx(fl);
      expst = (st & ~32'h0000_81FF) | 32'(fl);
      reg_read(ent(idx, 0), rd); check($sformatf("R4 vec%0d writeback", k), 64'(rd), 64'(expst));
      reg_read(11'h004, rd); check($sformatf("R6 vec%0d irq", k), 64'(rd), 64'(expirq));
      reg_write(11'h004, 32'h1F);
    end

    // R11 transmit restart: pointer sits at 1, both 0 and 1 ready
    reg_write(11'h000, 32'h0);
    reg_write(ent(0, 1), 32'h0000_A000);
    reg_write(ent(0, 0), 32'h0010_8000);
    reg_write(ent(1, 1), 32'h0000_A100);
    reg_write(ent(1, 0), 32'h0010_8000);
    reg_write(11'h000, 32'h2);
    wait_tx("R11");
    check("R11 restart at entry 0", 64'(tx_buf_addr), 64'h0000_A000);
    pulse_tx(9'h0);
    wait_tx("R5 next");
    check("R5 next entry", 64'(tx_buf_addr), 64'h0000_A100);
    pulse_tx(9'h0);
    @(negedge clk);
    check("R6 no irq bit, no source", 64'(irq), 64'd0);

    // receive: ring starts at entry 4
    reg_write(ent(4, 1), 32'h0000_2000);
    reg_write(ent(4, 0), 32'h0000_C000);
    reg_write(ent(5, 1), 32'h0000_2600);
    reg_write(ent(5, 0), 32'h0000_A000);
    reg_write(11'h000, 32'h3);
    @(negedge clk);
    check("R7 R8 first rx entry", {31'd0, rx_ready, rx_buf_addr}, {31'd1, 32'h0000_2000});
    pulse_rx(16'h0044, 9'h000);
    reg_read(ent(4, 0), rd); check("R7 rx fill", 64'(rd), 64'h0044_4000);
    reg_read(11'h004, rd); check("R10 rx done", 64'(rd), 64'h04);
    check("R12 irq line high", 64'(irq), 64'd1);
    reg_write(11'h004, 32'h04);
    reg_read(11'h004, rd); check("R12 clear", {31'd0, irq, rd}, 64'd0);

    check("R7 second entry", {31'd0, rx_ready, rx_buf_addr}, {31'd1, 32'h0000_2600});
    pulse_rx(16'h0050, 9'h102);
    reg_read(ent(5, 0), rd); check("R7 rx flags", 64'(rd), 64'h0050_2102);
    reg_read(11'h004, rd); check("R10 rx error", 64'(rd), 64'h08);
    reg_write(11'h004, 32'h1F);

    // R8 wrapped back to entry 4, now owned by software
    check("R8 wrap to first rx", {31'd0, rx_ready, rx_buf_addr}, {31'd0, 32'h0000_2000});
    pulse_rx(16'h0099, 9'h000);
    reg_read(11'h004, rd); check("R9 busy", 64'(rd), 64'h10);
    reg_read(ent(4, 0), rd); check("R9 entry untouched", 64'(rd), 64'h0044_4000);
    reg_write(11'h004, 32'h1F);

    // R10 control frame alone, pointer still at 4 after the drop
    reg_write(ent(4, 0), 32'h0000_C000);
    pulse_rx(16'h0040, 9'h100);
    reg_read(ent(4, 0), rd); check("R9 pointer held", 64'(rd), 64'h0040_4100);
    reg_read(11'h004, rd); check("R10 control frame ok", 64'(rd), 64'h04);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule